// File: doc/BRIEF.md
# Write-Through Snooping Data Cache Controller

This block is the data cache controller of one processor in a shared-bus multiprocessor. The cache is direct-mapped and has 16 lines of 8 words of 32 bits. Each line keeps one valid bit and one tag. Memory is always current: every processor store goes straight to memory as a single word, and line fills are always read from memory.

The processor side uses a request/ready handshake. A read that hits is answered in the cycle it is presented. A read that misses first wins the shared bus through a request/grant pair. It then reads the whole line in eight back-to-back beats, keeping the grant for all of them, and returns the requested word in the next cycle. A store always wins the bus and writes one word to memory. If the store hits, the cached copy is updated in the same cycle. A store that misses does not bring its line into the cache.

A snoop port reports every write that another master puts on the bus. If a snooped write lands in a line held here with a matching tag, that line is dropped. Snooped writes that miss are ignored. When a snoop and a local lookup fall on the same index in the same cycle, the invalidation takes effect first.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset, every line is invalid: `cpu_ready` and `bus_req` are low, and the first read of any address is a miss.
- R2: A read miss issues exactly 8 `mem_rd` beats on consecutive cycles. The beats cover word offsets 0 to 7 in ascending order, in address bits [4:2] of the missed line. `cpu_ready` rises in the cycle right after the last beat, carrying the requested word as read from memory.
- R3: A read hit raises `cpu_ready` in the same cycle as the request, with the cached word, and makes no bus request.
- R4: A write miss performs one `mem_wr` of the word-aligned address and data, and allocates nothing: a later read of that address misses.
- R5: A write hit performs the same single `mem_wr` and updates the cached word, so a later read hits and returns the new value.
- R6: For a write, `cpu_ready` is high only in the single cycle in which `mem_wr` is high.
- R7: A snooped write (`snoop_wr` high) whose index and tag match a valid line clears that line. The next read of that line misses and returns the memory value.
- R8: A snooped write whose tag differs from the line held at its index has no effect: a following read of the held line still hits.
- R9: If a snoop invalidates the line at the index a read looks up in the same cycle, the read is treated as a miss.
- R10: `mem_rd` and `mem_wr` are driven only while both `bus_req` and `bus_gnt` are high, and `bus_req` stays high for the whole fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access complete in this cycle |
| bus_req | output | 1 | Shared-bus request |
| bus_gnt | input | 1 | Shared-bus grant |
| mem_rd | output | 1 | Line-fill beat read |
| mem_wr | output | 1 | Single-word write-through |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write-through data |
| mem_rdata | input | 32 | Read data, same cycle as `mem_rd` |
| snoop_wr | input | 1 | Another master writes on the bus this cycle |
| snoop_addr | input | 32 | Address of the snooped write |

## Verification
The hardest case to reach is a snoop that falls on the same index in the very cycle a read is looked up. If the invalidation lost that race, stale data would be served without any fill. The bench reaches it by driving `snoop_wr` in the same half-cycle as a read request to another word of a line it has just filled. It expects eight fill beats rather than a same-cycle hit. A reference model in the bench keeps its own memory image and line table. It is applied to a seeded mix of loads, stores and snoops over a few kilobytes of address space, with a varying grant delay, so that index conflicts between stores, fills and snoops keep recurring.

// File: rtl/wtc_pkg.sv
// Shared types for the write-through snooping cache controller.
// Assumes nothing beyond IEEE 1800-2017.
package wtc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_REQ,
        ST_FILL,
        ST_RESP,
        ST_WR_REQ,
        ST_WR
    } wtc_state_e;
endpackage

// File: rtl/wtc_tag_array.sv
// Valid/tag store for a direct-mapped cache.
// Looks up one index per cycle, sets a line on fill completion and clears a line
// on a matching snooped write. A same-cycle invalidation of the looked-up index
// forces the lookup to miss. Assumes fill and snoop never hit one line together.
module wtc_tag_array #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             fill_set,
    input  logic             sn_valid,
    input  logic [IDX_W-1:0] sn_idx,
    input  logic [TAG_W-1:0] sn_tag,
    output logic             lk_hit
);
    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];
    logic                 sn_hit;

    // Snooped write matches a resident line.
    assign sn_hit = sn_valid && valid_q[sn_idx] && (tag_q[sn_idx] == sn_tag);
    // Local lookup, with invalidation taking priority on the same index.
    assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag)
                    && !(sn_hit && (sn_idx == lk_idx));

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
        // Per-line valid bit: cleared by reset or snoop, set by fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[gi] <= 1'b0;
            end else if (sn_hit && (sn_idx == IDX_W'(gi))) begin
                valid_q[gi] <= 1'b0;
            end else if (fill_set && (lk_idx == IDX_W'(gi))) begin
                valid_q[gi] <= 1'b1;
            end
        end

        // Per-line tag, written when the line is filled.
        always_ff @(posedge clk) begin
            if (fill_set && (lk_idx == IDX_W'(gi))) begin
                tag_q[gi] <= lk_tag;
            end
        end
    end
endmodule

// File: rtl/wtc_data_array.sv
// Word storage for the cache lines: one write port, one combinational read port.
// Assumes LINE_WORDS and NUM_LINES are powers of two.
module wtc_data_array #(
    parameter int DATA_W     = 32,
    parameter int NUM_LINES  = 16,
    parameter int LINE_WORDS = 8,
    parameter int IDX_W      = 4,
    parameter int WOFF_W     = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WOFF_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [WOFF_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = NUM_LINES * LINE_WORDS;

    logic [DATA_W-1:0] words_q [DEPTH];

    // Write one word of a line.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[{idx, wr_word}] <= wr_data;
        end
    end

    // Read the addressed word.
    assign rd_data = words_q[{idx, rd_word}];
endmodule

// File: rtl/wtc_ctrl.sv
// Sequencer for the write-through cache: answers hits, runs line fills and
// write-throughs under bus request/grant, and drives the array write port.
// Assumes the arbiter holds bus_gnt while bus_req stays high and that memory
// returns mem_rdata in the same cycle as mem_rd.
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              arr_we,
    output logic [$clog2(LINE_WORDS)-1:0] arr_word,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              fill_set,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int BOFF_W = $clog2(DATA_W / 8);
    localparam int WOFF_W = $clog2(LINE_WORDS);
    localparam int LINE_W = ADDR_W - WOFF_W - BOFF_W;
    localparam logic [WOFF_W-1:0] LAST_BEAT = WOFF_W'(LINE_WORDS - 1);

    wtc_state_e        state_q, state_d;
    logic [WOFF_W-1:0] beat_q;
    logic [DATA_W-1:0] resp_q;
    logic [WOFF_W-1:0] cpu_word;
    logic [LINE_W-1:0] line_base;

    assign cpu_word  = cpu_addr[BOFF_W +: WOFF_W];
    assign line_base = cpu_addr[ADDR_W-1 -: LINE_W];

    // Next state and all handshake outputs.
    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        cpu_rdata = arr_rdata;
        bus_req   = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        arr_we    = 1'b0;
        arr_word  = cpu_word;
        arr_wdata = cpu_wdata;
        fill_set  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we)      state_d = ST_WR_REQ;
                    else if (lk_hit) cpu_ready = 1'b1;
                    else             state_d = ST_FILL_REQ;
                end
            end
            ST_FILL_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) state_d = ST_FILL;
            end
            ST_FILL: begin
                bus_req   = 1'b1;
                mem_rd    = 1'b1;
                mem_addr  = {line_base, beat_q, {BOFF_W{1'b0}}};
                arr_we    = 1'b1;
                arr_word  = beat_q;
                arr_wdata = mem_rdata;
                if (beat_q == LAST_BEAT) begin
                    fill_set = 1'b1;
                    state_d  = ST_RESP;
                end
            end
            ST_RESP: begin
                cpu_ready = 1'b1;
                cpu_rdata = resp_q;
                state_d   = ST_IDLE;
            end
            ST_WR_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) state_d = ST_WR;
            end
            ST_WR: begin
                bus_req   = 1'b1;
                mem_wr    = 1'b1;
                mem_addr  = {cpu_addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
                mem_wdata = cpu_wdata;
                arr_we    = lk_hit;
                cpu_ready = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and fill beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL) beat_q <= beat_q + 1'b1;
            else                    beat_q <= '0;
        end
    end

    // Capture the requested word as it streams past during the fill.
    always_ff @(posedge clk) begin
        if (state_q == ST_FILL && beat_q == cpu_word) begin
            resp_q <= mem_rdata;
        end
    end
endmodule

// File: rtl/wt_snoop_cache.sv
// Top of the write-through snooping cache controller. It splits addresses into
// tag/index/word/byte fields and joins the tag store, the data store and the
// sequencer. It assumes snooped writes arrive only while this cache does not
// hold the bus.
module wt_snoop_cache #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int NUM_LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              snoop_wr,
    input  logic [ADDR_W-1:0] snoop_addr
);
    localparam int BOFF_W  = $clog2(DATA_W / 8);
    localparam int WOFF_W  = $clog2(LINE_WORDS);
    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int IDX_LSB = BOFF_W + WOFF_W;
    localparam int TAG_LSB = IDX_LSB + IDX_W;
    localparam int TAG_W   = ADDR_W - TAG_LSB;

    logic              lk_hit, fill_set, arr_we;
    logic [WOFF_W-1:0] arr_word;
    logic [DATA_W-1:0] arr_wdata, arr_rdata;
    logic              unused_snoop_low;

    assign unused_snoop_low = ^snoop_addr[IDX_LSB-1:0];

    wtc_tag_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (cpu_addr[IDX_LSB +: IDX_W]),
        .lk_tag   (cpu_addr[TAG_LSB +: TAG_W]),
        .fill_set (fill_set),
        .sn_valid (snoop_wr),
        .sn_idx   (snoop_addr[IDX_LSB +: IDX_W]),
        .sn_tag   (snoop_addr[TAG_LSB +: TAG_W]),
        .lk_hit   (lk_hit)
    );

    wtc_data_array #(.DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS),
                     .IDX_W(IDX_W), .WOFF_W(WOFF_W)) u_data (
        .clk     (clk),
        .wr_en   (arr_we),
        .idx     (cpu_addr[IDX_LSB +: IDX_W]),
        .wr_word (arr_word),
        .wr_data (arr_wdata),
        .rd_word (cpu_addr[BOFF_W +: WOFF_W]),
        .rd_data (arr_rdata)
    );

    wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready),
        .lk_hit    (lk_hit),
        .arr_rdata (arr_rdata),
        .arr_we    (arr_we),
        .arr_word  (arr_word),
        .arr_wdata (arr_wdata),
        .fill_set  (fill_set),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );
endmodule

// File: rtl/wtc_checker.sv
// Protocol checker for wt_snoop_cache, attached by bind. It watches only the
// top-level ports and assumes the default word width of four bytes or more.
module wtc_checker #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int BOFF_W = $clog2(DATA_W / 8);
    localparam int WOFF_W = $clog2(LINE_WORDS);
    localparam logic [WOFF_W-1:0] LAST_BEAT = WOFF_W'(LINE_WORDS - 1);

    logic [WOFF_W-1:0] woff;
    logic              unused_addr;

    assign woff        = mem_addr[BOFF_W +: WOFF_W];
    assign unused_addr = ^{mem_addr[ADDR_W-1:BOFF_W+WOFF_W], mem_addr[BOFF_W-1:0]};

    // R10: fill beats only under a held grant
    a_r10_rd_granted: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (bus_req && bus_gnt));

    // R10: write-through only under a held grant
    a_r10_wr_granted: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (bus_req && bus_gnt));

    // R2: a fill starts at word offset zero
    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |-> (woff == '0));

    // R2: beats follow back to back in ascending order
    a_r2_beats_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && woff != LAST_BEAT) |=> (mem_rd && woff == $past(woff) + 1'b1));

    // R2: the word is returned right after the last beat
    a_r2_ready_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd) |-> cpu_ready);

    // R6: a store completes only together with its memory write
    a_r6_write_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_ready) |-> mem_wr);

    // R6: one write-through per store
    a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);
endmodule

bind wt_snoop_cache wtc_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_ready (cpu_ready),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr)
);

// File: tb/sim_wt_snoop_cache.sv
`timescale 1ns/1ps
// Self-checking bench: a memory and an arbiter as the environment, and a
// behavioural model (memory image plus line table) predicting every access.
module sim_wt_snoop_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready, bus_req, mem_rd, mem_wr;
    logic        bus_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        snoop_wr = 1'b0;
    logic [31:0] snoop_addr = '0, snoop_data = '0;

    int          checks = 0, fails = 0;
    int          gnt_delay = 0, gcnt;
    int          total_rd = 0, total_wr = 0, fill_cnt = 0;
    logic [31:0] last_wr_addr, last_wr_data;
    logic [31:0] memory  [1024];
    logic [31:0] exp_mem [1024];
    bit          m_valid [16];
    int          m_tag   [16];

    always #2.5 clk = ~clk;

    wt_snoop_cache u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .snoop_wr(snoop_wr), .snoop_addr(snoop_addr)
    );

    function automatic logic [31:0] init_word(int i);
        return 32'hC0DE0000 ^ (i * 32'h00009E37);
    endfunction

    task automatic check(string req, bit ok, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Environment memory: fills read combinationally, writes land at the edge.
    assign mem_rdata = memory[mem_addr[11:2]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) memory[i] <= init_word(i);
        end else begin
            if (mem_wr)   memory[mem_addr[11:2]]   <= mem_wdata;
            if (snoop_wr) memory[snoop_addr[11:2]] <= snoop_data;
        end
    end

    // Arbiter: grant after gnt_delay cycles, held while requested.
    always @(posedge clk) begin
        if (!rst_n || !bus_req) begin
            bus_gnt <= 1'b0;
            gcnt    <= gnt_delay;
        end else if (gcnt != 0) begin
            gcnt <= gcnt - 1;
        end else begin
            bus_gnt <= 1'b1;
        end
    end

    // Per-clock monitor: bus discipline and fill beat order.
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_rd || mem_wr) check("R10 grant", bus_gnt && bus_req, {31'd0, bus_gnt}, 32'd1);
            if (mem_rd) begin
                check("R2 beat order", mem_addr[4:2] == fill_cnt[2:0], {29'd0, mem_addr[4:2]}, fill_cnt);
                fill_cnt = fill_cnt + 1;
                total_rd = total_rd + 1;
            end else begin
                fill_cnt = 0;
            end
            if (mem_wr) begin
                total_wr     = total_wr + 1;
                last_wr_addr = mem_addr;
                last_wr_data = mem_wdata;
            end
        end
    end

    function automatic bit model_hit(logic [31:0] a);
        return m_valid[(a >> 5) & 15] && m_tag[(a >> 5) & 15] == int'(a >> 9);
    endfunction

    task automatic model_snoop(logic [31:0] a, logic [31:0] d);
        if (model_hit(a)) m_valid[(a >> 5) & 15] = 1'b0;
        exp_mem[a[11:2]] = d;
    endtask

    // Assumes the caller is at a falling edge.
    task automatic do_read(logic [31:0] a, bit with_snoop, logic [31:0] sa,
                           logic [31:0] sd, string req);
        bit          exp_hit;
        logic [31:0] exp_data, got;
        int          waits = 0, rd0 = total_rd;
        if (with_snoop) begin
            model_snoop(sa, sd);
            snoop_wr = 1'b1; snoop_addr = sa; snoop_data = sd;
        end
        exp_hit  = model_hit(a);
        exp_data = exp_mem[a[11:2]];
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            snoop_wr = 1'b0;
            waits++;
            #1;
        end
        got = cpu_rdata;
        @(negedge clk);
        snoop_wr = 1'b0;
        cpu_req  = 1'b0;
        check(req, got == exp_data, got, exp_data);
        check(req, (total_rd - rd0) == (exp_hit ? 0 : 8), total_rd - rd0, exp_hit ? 0 : 8);
        if (exp_hit) check(req, waits == 0, waits, 0);
        if (!exp_hit) begin
            m_valid[(a >> 5) & 15] = 1'b1;
            m_tag[(a >> 5) & 15]   = int'(a >> 9);
        end
    endtask

    task automatic do_write(logic [31:0] a, logic [31:0] d, string req);
        int wr0 = total_wr;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cpu_req = 1'b0;
        check(req, (total_wr - wr0) == 1, total_wr - wr0, 1);
        check(req, last_wr_addr == a && last_wr_data == d, last_wr_data, d);
        exp_mem[a[11:2]] = d;
    endtask

    task automatic do_snoop(logic [31:0] a, logic [31:0] d);
        model_snoop(a, d);
        snoop_wr = 1'b1; snoop_addr = a; snoop_data = d;
        @(negedge clk);
        snoop_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog actual=hung expected=completed");
        finish_run();
    end

    initial begin
        int unsigned seed = 32'h1234_5678;
        for (int i = 0; i < 1024; i++) exp_mem[i] = init_word(i);
        for (int i = 0; i < 16; i++) m_valid[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 reset outputs", !cpu_ready && !bus_req, {30'd0, cpu_ready, bus_req}, 32'd0);
        @(negedge clk);

        do_read(32'h100, 0, 0, 0, "R1 first read misses");
        do_read(32'h104, 0, 0, 0, "R3 read hit");
        gnt_delay = 2;
        do_write(32'h108, 32'hDEAD_0108, "R5 write hit");
        do_read(32'h108, 0, 0, 0, "R5 updated word hit");
        do_write(32'h800, 32'hBEEF_0800, "R4 write miss");
        do_read(32'h800, 0, 0, 0, "R4 no allocate");
        do_snoop(32'h110, 32'h5A5A_0110);
        do_read(32'h110, 0, 0, 0, "R7 snoop invalidates");
        do_snoop(32'h310, 32'h0BAD_0310);
        do_read(32'h114, 0, 0, 0, "R8 snoop other tag ignored");
        do_read(32'h118, 1, 32'h11C, 32'h7777_011C, "R9 same cycle snoop");
        do_read(32'h11C, 0, 0, 0, "R9 snooped word visible");

        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            seed = seed * 32'd1664525 + 32'd1013904223;
            a = {20'd0, seed[27:18], 2'b00};
            gnt_delay = int'(seed[5:4]);
            case (seed[31:30])
                2'd0, 2'd1: do_read(a, seed[8] & seed[9], {20'd0, seed[17:8], 2'b00}, seed ^ 32'h3C3C, "R2 mixed read");
                2'd2:       do_write(a, seed ^ 32'hA5A5_0000, "R5 mixed write");
                default:    do_snoop(a, seed ^ 32'h0F0F_F0F0);
            endcase
        end
        finish_run();
    end
endmodule